// File: doc/BRIEF.md
# Thermal threshold interrupt monitor

This block watches the filtered readings of up to four temperature sensor channels. Each time a channel presents a new reading, the block compares it with three programmable raw thresholds: hot, hot-to-normal and cold. It keeps a two-state zone tracker (normal or hot) for each channel. The tracker enters hot when a reading reaches the hot threshold and returns to normal only when a reading falls to the lower hot-to-normal threshold, so the band between the two thresholds gives hysteresis.

Events are latched into a 32-bit status word with a fixed, irregular bit layout. Software clears the word by writing ones to the bits it wants removed. A single interrupt line is raised whenever an unmasked status bit is set. A small write-only register port loads the thresholds, the channel enables, the hot-event mode, the interrupt mask and the clear strobe. Larger raw values mean hotter temperatures. The status word and the per-channel zone are visible at the ports.

Top module: `therm_irq_mon`

## Requirements
- R1: After synchronous active-low reset, status_o is 0, irq_o is 0 and every bit of zone_hot_o is 0 (normal).
- R2: A write with wr_en_i high updates one register, chosen by wr_addr_i. Address 0 holds the hot threshold, 1 the hot-to-normal threshold and 2 the cold threshold; each threshold takes wr_data_i[14:0] and ignores the upper bits. Address 3 is control: bits [3:0] enable channels 0..3, and bit 8 selects single mode when 1 and repeat mode when 0. Address 4 is the 32-bit interrupt mask. Address 5 is the status clear.
- R3: A valid reading on an enabled channel that is at or below the cold threshold sets that channel's cold bit. The cold bits are 0, 5, 10 and 22 for channels 0 to 3.
- R4: A valid reading on an enabled channel in the normal zone that is at or above the hot threshold moves the channel to hot and sets its normal-to-hot bit. These bits are 4, 9, 14 and 26 for channels 0 to 3.
- R5: A channel in the hot zone stays hot until a valid reading is at or below the hot-to-normal threshold; it then returns to normal. No normal-to-hot bit is set while the channel stays hot.
- R6: In repeat mode, every valid reading on an enabled channel that is at or above the hot threshold sets that channel's hot bit. The hot bits are 1, 6, 11 and 23 for channels 0 to 3.
- R7: In single mode, the hot bit is set only on the reading that moves the channel from normal to hot.
- R8: Readings on a disabled channel set no status bit, and the channel's zone is normal from the cycle after it is disabled.
- R9: A write to address 5 clears exactly the status bits written as one; bits written as zero keep their value.
- R10: If hardware sets a status bit in the same cycle that a clear names it, the bit ends up set.
- R11: irq_o is 1 exactly when some status bit and the same mask bit are both 1.
- R12: Status bits other than the twelve listed in R3, R4 and R6 always read as 0.
- R13: A reading whose valid bit is low has no effect on status or zone.
- R14: A status bit or zone change caused by a reading or write at one clock edge is visible on the outputs directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_valid_i | input | 4 | Per-channel new-reading strobe |
| rd_temp_i | input | 60 | Per-channel 15-bit raw readings, channel n at bits [15n+14:15n] |
| status_o | output | 32 | Latched event status |
| zone_hot_o | output | 4 | Per-channel zone, 1 = hot |
| irq_o | output | 1 | Masked OR of the status bits |

## Verification
The bench uses the default build of four channels with 15-bit readings, so every status bit in the irregular layout and every channel's tracker can be reached. Near thresholds of 100, 80 and 20, each channel follows a phase-shifted triangle of readings between 0 and 139. Over that sweep every reading crosses the cold level, the hysteresis band and the hot level in both directions, in repeat mode and in single mode. Valid strobes are dropped and clear writes come at regular intervals during the sweep, so collisions between a clear and a set of the same bit occur within the sweep. Directed steps cover channel disable, a partial mask, partial clears and threshold writes whose upper data bits are set.

// File: rtl/therm_mon_pkg.sv
// Shared constants and helpers for the thermal threshold interrupt monitor.
// Assumes at most four sensor channels; the status layout is fixed at 32 bits.
package therm_mon_pkg;

    localparam int STAT_W      = 32;
    localparam int MAX_SENSORS = 4;
    localparam int ADDR_W      = 3;

    // register addresses on the write port
    localparam logic [ADDR_W-1:0] A_HOT_THR = 3'd0;
    localparam logic [ADDR_W-1:0] A_RET_THR = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLD_THR = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK    = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 3'd5;

    // control word field position for the hot-event mode
    localparam int CTRL_SINGLE_BIT = 8;

    typedef enum logic {
        ZONE_NORMAL = 1'b0,
        ZONE_HOT    = 1'b1
    } zone_t;

    // status bit of the cold event for channel s
    function automatic int cold_pos(input int s);
        case (s)
            0:       return 0;
            1:       return 5;
            2:       return 10;
            default: return 22;
        endcase
    endfunction

    // status bit of the hot event for channel s (always next to cold)
    function automatic int hot_pos(input int s);
        return cold_pos(s) + 1;
    endfunction

    // status bit of the normal-to-hot transition for channel s
    function automatic int n2h_pos(input int s);
        case (s)
            0:       return 4;
            1:       return 9;
            2:       return 14;
            default: return 26;
        endcase
    endfunction

    // mask of all status bits defined for ns channels
    function automatic logic [STAT_W-1:0] defined_mask(input int ns);
        logic [STAT_W-1:0] m;
        m = '0;
        for (int s = 0; s < ns; s++) begin
            m[cold_pos(s)] = 1'b1;
            m[hot_pos(s)]  = 1'b1;
            m[n2h_pos(s)]  = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/therm_cfg_regs.sv
// Configuration register file on the write-only register port.
// Holds thresholds, channel enables, hot-event mode and interrupt mask,
// and turns writes to the clear address into a one-cycle clear strobe.
// Assumes one write per cycle; unknown addresses are ignored.
module therm_cfg_regs
    import therm_mon_pkg::*;
#(
    parameter int TEMP_W   = 15,
    parameter int NUM_SENS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [STAT_W-1:0]     wr_data_i,
    output logic [TEMP_W-1:0]     hot_thr_o,
    output logic [TEMP_W-1:0]     ret_thr_o,
    output logic [TEMP_W-1:0]     cld_thr_o,
    output logic [NUM_SENS-1:0]   sens_en_o,
    output logic                  single_o,
    output logic [STAT_W-1:0]     mask_o,
    output logic [STAT_W-1:0]     clr_o
);

    logic wr_hot, wr_ret, wr_cld, wr_ctl, wr_msk;

    // decode the write strobe per address
    always_comb begin
        wr_hot = wr_en_i && (wr_addr_i == A_HOT_THR);
        wr_ret = wr_en_i && (wr_addr_i == A_RET_THR);
        wr_cld = wr_en_i && (wr_addr_i == A_CLD_THR);
        wr_ctl = wr_en_i && (wr_addr_i == A_CTRL);
        wr_msk = wr_en_i && (wr_addr_i == A_MASK);
    end

    // threshold registers keep only the low TEMP_W data bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_thr_o <= '0;
            ret_thr_o <= '0;
            cld_thr_o <= '0;
        end else begin
            if (wr_hot) hot_thr_o <= wr_data_i[TEMP_W-1:0];
            if (wr_ret) ret_thr_o <= wr_data_i[TEMP_W-1:0];
            if (wr_cld) cld_thr_o <= wr_data_i[TEMP_W-1:0];
        end
    end

    // control and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sens_en_o <= '0;
            single_o  <= 1'b0;
            mask_o    <= '0;
        end else begin
            if (wr_ctl) begin
                sens_en_o <= wr_data_i[NUM_SENS-1:0];
                single_o  <= wr_data_i[CTRL_SINGLE_BIT];
            end
            if (wr_msk) mask_o <= wr_data_i;
        end
    end

    // clear strobe is passed straight through for the write cycle
    assign clr_o = (wr_en_i && (wr_addr_i == A_CLEAR)) ? wr_data_i : '0;

endmodule

// File: rtl/therm_zone_fsm.sv
// Per-channel normal/hot zone tracker with hysteresis and event detection.
// Events are combinational for the cycle in which a valid reading arrives;
// the zone register updates at the same edge. Assumes ret_thr <= hot_thr.
module therm_zone_fsm
    import therm_mon_pkg::*;
#(
    parameter int TEMP_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              vld_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] hot_thr_i,
    input  logic [TEMP_W-1:0] ret_thr_i,
    input  logic [TEMP_W-1:0] cld_thr_i,
    input  logic              single_i,
    output logic              ev_cold_o,
    output logic              ev_hot_o,
    output logic              ev_n2h_o,
    output logic              hot_o
);

    zone_t zone_q, zone_d;
    logic  take, at_hot, at_ret, at_cold;

    // compare a sampled reading against the three thresholds
    always_comb begin
        take    = en_i && vld_i;
        at_hot  = temp_i >= hot_thr_i;
        at_ret  = temp_i <= ret_thr_i;
        at_cold = temp_i <= cld_thr_i;
    end

    // next zone and event flags
    always_comb begin
        zone_d    = zone_q;
        ev_cold_o = 1'b0;
        ev_hot_o  = 1'b0;
        ev_n2h_o  = 1'b0;
        if (!en_i) begin
            zone_d = ZONE_NORMAL;
        end else if (take) begin
            ev_cold_o = at_cold;
            if (zone_q == ZONE_NORMAL) begin
                if (at_hot) begin
                    zone_d   = ZONE_HOT;
                    ev_n2h_o = 1'b1;
                    ev_hot_o = 1'b1;
                end
            end else begin
                if (at_ret) zone_d = ZONE_NORMAL;
                ev_hot_o = at_hot && !single_i;
            end
        end
    end

    // zone register
    always_ff @(posedge clk) begin
        if (!rst_n) zone_q <= ZONE_NORMAL;
        else        zone_q <= zone_d;
    end

    assign hot_o = (zone_q == ZONE_HOT);

    // R4
    enter_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && vld_i && !hot_o && temp_i >= hot_thr_i) |=> hot_o);

    // R5
    hold_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && hot_o && !(vld_i && temp_i <= ret_thr_i)) |=> hot_o);

    // R8
    disabled_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !hot_o);

    // R7
    single_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single_i && hot_o) |-> !ev_hot_o);

endmodule

// File: rtl/therm_status_reg.sv
// Write-one-to-clear event status word and masked interrupt output.
// A hardware set in the same cycle as a clear of that bit wins.
// Assumes set_i only drives defined bits (DEF_MASK filters the rest anyway).
module therm_status_reg
    import therm_mon_pkg::*;
#(
    parameter logic [STAT_W-1:0] DEF_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] clr_i,
    input  logic [STAT_W-1:0] mask_i,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    logic [STAT_W-1:0] status_q;

    // latch events, clear written ones, keep reserved bits at zero
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((status_q & ~clr_i) | set_i) & DEF_MASK;
    end

    assign status_o = status_q;

    // interrupt line
    assign irq_o = |(status_q & mask_i);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & DEF_MASK) != '0) |=> ((status_q & $past(set_i & DEF_MASK)) == $past(set_i & DEF_MASK)));

    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((status_q & $past(clr_i)) == '0));

    // R9
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~DEF_MASK) == '0);

endmodule

// File: rtl/therm_irq_mon.sv
// Top of the thermal threshold interrupt monitor.
// Instantiates the register file, one zone tracker per channel and the
// status word, and maps channel events onto the fixed status layout.
// Assumes NUM_SENS between 1 and 4.
module therm_irq_mon
    import therm_mon_pkg::*;
#(
    parameter int TEMP_W   = 15,
    parameter int NUM_SENS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [STAT_W-1:0]          wr_data_i,
    input  logic [NUM_SENS-1:0]        rd_valid_i,
    input  logic [NUM_SENS*TEMP_W-1:0] rd_temp_i,
    output logic [STAT_W-1:0]          status_o,
    output logic [NUM_SENS-1:0]        zone_hot_o,
    output logic                       irq_o
);

    localparam logic [STAT_W-1:0] DEF_MASK = defined_mask(NUM_SENS);

    logic [TEMP_W-1:0]   hot_thr, ret_thr, cld_thr;
    logic [NUM_SENS-1:0] sens_en;
    logic                single_mode;
    logic [STAT_W-1:0]   irq_mask, clr_vec, set_vec;
    logic [NUM_SENS-1:0] ev_cold, ev_hot, ev_n2h;

    therm_cfg_regs #(
        .TEMP_W   (TEMP_W),
        .NUM_SENS (NUM_SENS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .hot_thr_o (hot_thr),
        .ret_thr_o (ret_thr),
        .cld_thr_o (cld_thr),
        .sens_en_o (sens_en),
        .single_o  (single_mode),
        .mask_o    (irq_mask),
        .clr_o     (clr_vec)
    );

    for (genvar s = 0; s < NUM_SENS; s++) begin : g_chan
        therm_zone_fsm #(
            .TEMP_W (TEMP_W)
        ) u_zone (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (sens_en[s]),
            .vld_i     (rd_valid_i[s]),
            .temp_i    (rd_temp_i[s*TEMP_W +: TEMP_W]),
            .hot_thr_i (hot_thr),
            .ret_thr_i (ret_thr),
            .cld_thr_i (cld_thr),
            .single_i  (single_mode),
            .ev_cold_o (ev_cold[s]),
            .ev_hot_o  (ev_hot[s]),
            .ev_n2h_o  (ev_n2h[s]),
            .hot_o     (zone_hot_o[s])
        );
    end

    // place channel events at their fixed status positions
    always_comb begin
        set_vec = '0;
        for (int s = 0; s < NUM_SENS; s++) begin
            set_vec[cold_pos(s)] = ev_cold[s];
            set_vec[hot_pos(s)]  = ev_hot[s];
            set_vec[n2h_pos(s)]  = ev_n2h[s];
        end
    end

    therm_status_reg #(
        .DEF_MASK (DEF_MASK)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_i    (clr_vec),
        .mask_i   (irq_mask),
        .status_o (status_o),
        .irq_o    (irq_o)
    );

endmodule

// File: tb/therm_irq_mon_tb.sv
`timescale 1ns/1ps
module therm_irq_mon_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_valid = '0;
    logic [59:0] rd_temp = '0;
    logic [31:0] status;
    logic [3:0]  zone_hot;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    logic [31:0] m_status = '0, m_mask = '0;
    logic [3:0]  m_hot = '0, m_en = '0;
    logic        m_single = 1'b0;
    logic [14:0] m_hthr = '0, m_rthr = '0, m_cthr = '0;

    always #2 clk = ~clk;

    therm_irq_mon u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_valid_i (rd_valid),
        .rd_temp_i  (rd_temp),
        .status_o   (status),
        .zone_hot_o (zone_hot),
        .irq_o      (irq)
    );

    function automatic int cpos(input int s);
        int t[4] = '{0, 5, 10, 22};
        return t[s];
    endfunction
    function automatic int npos(input int s);
        int t[4] = '{4, 9, 14, 26};
        return t[s];
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // one clock of stimulus, model update and output comparison (R14)
    task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                        input logic [3:0] vld, input logic [14:0] t0, input logic [14:0] t1,
                        input logic [14:0] t2, input logic [14:0] t3, input string req);
        logic [14:0] tv[4];
        logic [31:0] setv, clrv;
        logic [3:0]  nh;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; rd_valid = vld;
        rd_temp = {t3, t2, t1, t0};
        tv[0] = t0; tv[1] = t1; tv[2] = t2; tv[3] = t3;
        setv = '0; nh = m_hot;
        for (int s = 0; s < 4; s++) begin
            if (!m_en[s]) nh[s] = 1'b0;
            else if (vld[s]) begin
                if (tv[s] <= m_cthr) setv[cpos(s)] = 1'b1;
                if (!m_hot[s]) begin
                    if (tv[s] >= m_hthr) begin
                        nh[s] = 1'b1;
                        setv[npos(s)] = 1'b1;
                        setv[cpos(s) + 1] = 1'b1;
                    end
                end else begin
                    if (tv[s] <= m_rthr) nh[s] = 1'b0;
                    if (!m_single && tv[s] >= m_hthr) setv[cpos(s) + 1] = 1'b1;
                end
            end
        end
        clrv = (we && a == 3'd5) ? d : '0;
        m_status = (m_status & ~clrv) | setv;
        m_hot = nh;
        if (we) begin
            case (a)
                3'd0: m_hthr = d[14:0];
                3'd1: m_rthr = d[14:0];
                3'd2: m_cthr = d[14:0];
                3'd3: begin m_en = d[3:0]; m_single = d[8]; end
                3'd4: m_mask = d;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        check(req, "status", status, m_status);
        check(req, "irq", {31'd0, irq}, {31'd0, |(m_status & m_mask)});
        check(req, "zone", {28'd0, zone_hot}, {28'd0, m_hot});
        wr_en = 1'b0; rd_valid = '0;
    endtask

    task automatic idle(input string req);
        step(1'b0, 3'd0, 32'd0, 4'd0, 15'd0, 15'd0, 15'd0, 15'd0, req);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
        step(1'b1, a, d, 4'd0, 15'd0, 15'd0, 15'd0, 15'd0, req);
    endtask

    task automatic all4(input logic [3:0] vld, input logic [14:0] t, input string req);
        step(1'b0, 3'd0, 32'd0, vld, t, t, t, t, req);
    endtask

    function automatic logic [14:0] tri_val(input int t);
        int v;
        v = t % 280;
        return (v < 140) ? 15'(v) : 15'(279 - v);
    endfunction

    // sweep of phase-shifted triangles with dropped strobes and periodic clears
    task automatic sweep(input int len, input string req);
        logic [3:0]  vld;
        logic        we;
        logic [31:0] d;
        for (int t = 0; t < len; t++) begin
            vld = 4'hF;
            if (t % 7 == 3) vld[t % 4] = 1'b0;
            we = (t % 16 == 15);
            d  = (t % 32 == 15) ? 32'hFFFF_FFFF : 32'h0F0F_0F0F;
            step(we, 3'd5, d, vld, tri_val(t), tri_val(t + 37), tri_val(t + 74), tri_val(t + 111), req);
        end
    endtask

    initial begin
        #(4.0 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        check("R1", "status", status, 32'd0);
        check("R1", "irq", {31'd0, irq}, 32'd0);
        check("R1", "zone", {28'd0, zone_hot}, 32'd0);
        idle("R1");

        // configuration with junk in the upper data bits (R2)
        wr(3'd0, 32'hFFFF_0064, "R2");
        wr(3'd1, 32'hABCD_0050, "R2");
        wr(3'd2, 32'h8000_0014, "R2");
        wr(3'd4, 32'hFFFF_FFFF, "R2");
        wr(3'd3, 32'h0000_000F, "R2");
        all4(4'hF, 15'd100, "R2");

        // repeat mode sweep (R3 R4 R5 R6 R9 R10 R13)
        sweep(700, "R3/R4/R5/R6");
        check("R12", "reserved", status & ~32'h04C0_4E73, 32'd0);

        // single mode sweep (R7)
        wr(3'd3, 32'h0000_010F, "R7");
        sweep(700, "R7");

        // known state: all normal, clear status
        wr(3'd3, 32'h0000_000F, "R13");
        all4(4'hF, 15'd50, "R13");
        wr(3'd5, 32'hFFFF_FFFF, "R13");
        all4(4'h0, 15'd130, "R13");
        all4(4'h0, 15'd5, "R13");

        // disable channel 2 while hot (R8)
        all4(4'hF, 15'd130, "R8");
        step(1'b1, 3'd3, 32'h0000_000B, 4'hF, 15'd130, 15'd130, 15'd130, 15'd130, "R8");
        all4(4'hF, 15'd5, "R8");
        wr(3'd5, 32'hFFFF_FFFF, "R8");
        step(1'b1, 3'd3, 32'h0000_000F, 4'hF, 15'd90, 15'd90, 15'd90, 15'd90, "R8");
        all4(4'hF, 15'd90, "R8");

        // partial mask (R11)
        all4(4'hF, 15'd10, "R11");
        wr(3'd5, 32'hFFFF_FFFF, "R11");
        wr(3'd4, 32'h0080_0000, "R11");
        step(1'b0, 3'd0, 32'd0, 4'h1, 15'd130, 15'd0, 15'd0, 15'd0, "R11");
        step(1'b0, 3'd0, 32'd0, 4'h8, 15'd0, 15'd0, 15'd0, 15'd130, "R11");
        wr(3'd5, 32'h0080_0000, "R11");

        // partial clear (R9)
        all4(4'hF, 15'd130, "R9");
        wr(3'd5, 32'h0000_0210, "R9");
        wr(3'd5, 32'h0000_0000, "R9");
        wr(3'd5, 32'hFFFF_FFFF, "R9");

        // set and clear of the same bit together (R10)
        step(1'b1, 3'd5, 32'h0000_0002, 4'h1, 15'd130, 15'd0, 15'd0, 15'd0, "R10");
        step(1'b1, 3'd5, 32'h0800_0C62, 4'hF, 15'd130, 15'd130, 15'd130, 15'd130, "R10");
        check("R12", "reserved", status & ~32'h04C0_4E73, 32'd0);

        finish_up();
    end

endmodule